// File: doc/BRIEF.md
# Cooccurrence Pair Counting Cache

This block tallies how often each ordered pair of gray levels shows up within one image window. A pair is a row level and a column level, each quantized to 64 values. Most windows touch only a small part of the 4096 possible pairs, so the block does not hold a dense matrix. It keeps a sparse set-associative store of 512 cells, arranged as 32 sets of 16 ways. Each cell holds a tag, a 16-bit count and a valid bit. A pair that is already present has its count raised by one. A new pair takes a free way in its set. A new pair that finds its set full is dropped and raises a sticky overflow flag, which tells the system to compute that window some other way.

A window opens with a one-cycle clear, which empties the store in one cycle. Pairs then arrive at up to one per cycle. After the last pair, a dump request walks the whole store and streams out every occupied cell as row, column and count. The last of these entries carries an end marker. In a typical system, four of these blocks sit side by side on one pixel stream, one for each neighbour direction.

Control is a two-state machine. In ACCUM the block takes pairs. In SCAN it streams the store. Its transitions are:
- ACCUM to SCAN on a dump request while the store is not empty.
- SCAN to ACCUM when the final entry is sent.
- Any state to ACCUM on clear.
- ACCUM holds when a dump request meets an empty store.

Top module: `cooc_pair_cache`

## Requirements
- R1: The pair key is {row, col}, 12 bits with row in the upper six. The set index is key[4:0], which is col[4:0]. The tag is key[11:5]. The store holds 32 sets of 16 ways, 512 cells in total.
- R2: In ACCUM, a valid pair whose key is stored raises that cell's count by one at the next clock edge. The same key on consecutive cycles is counted once per cycle.
- R3: A count already at 0xFFFF stays at 0xFFFF when its pair arrives again.
- R4: A valid pair whose key is absent, in a set with a free way, takes the lowest-numbered free way with a count of 1.
- R5: A valid pair whose key is absent, in a full set, is dropped and sets ovf_flag. The flag stays set until clear, and hits to stored keys keep counting while it is set.
- R6: win_clear invalidates every cell, drops ovf_flag and ends any readout in one cycle. A pair presented in the same cycle as the clear is discarded.
- R7: A dump request in ACCUM with a non-empty store enters SCAN. Every valid cell is then sent once, at most one per cycle, with rd_valid high. The order is ascending set index, and within a set ascending way, which is the order the keys were first seen.
- R8: rd_last is high together with rd_valid on the final entry only. The block is back in ACCUM from the following cycle.
- R9: In SCAN, pair inputs and dump requests are ignored, so the counts read afterwards are unchanged.
- R10: A dump request with an empty store produces no entry, and the block stays in ACCUM.
- R11: After reset the store is empty, and ovf_flag, rd_valid and rd_last are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_clear | input | 1 | Starts a new window: empties the store and clears overflow |
| pair_valid | input | 1 | Qualifies pair_row and pair_col this cycle |
| pair_row | input | 6 | Gray level of the center pixel |
| pair_col | input | 6 | Gray level of the neighbour pixel |
| dump_go | input | 1 | Requests a readout of the store |
| ovf_flag | output | 1 | Sticky: a distinct pair could not be stored in this window |
| rd_valid | output | 1 | Readout entry valid |
| rd_row | output | 6 | Row level of the readout entry |
| rd_col | output | 6 | Column level of the readout entry |
| rd_count | output | 16 | Count of the readout entry |
| rd_last | output | 1 | Marks the final readout entry |

## Verification
The bench targets several corner cases, each of which shows a distinct failure:
- A set filled to exactly sixteen ways. A wrong free-way search would flag overflow here or overwrite a live way.
- A seventeenth distinct key in one set. A design that lost it silently would leave ovf_flag low.
- Keys first seen in descending tag order. A way picker that followed the key value instead of the free slot would reorder the readout.
- A pair repeated more than 65535 times. Without saturation the count would wrap to a small value.
- A clear in the middle of a readout, and pairs and dump requests fed during SCAN. A design that kept streaming or kept counting would show stray entries or changed counts.
- The full 512-cell store, read out to confirm that rd_last falls on exactly the final cell.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [0:0] {
        ST_ACCUM = 1'b0,
        ST_SCAN  = 1'b1
    } pcc_state_e;

endpackage

// File: rtl/pcc_way_match.sv
// Parallel tag compare over one set, plus lowest-free-way pick.
module pcc_way_match #(
    parameter  int WAYS     = 16,
    parameter  int TAG_W    = 7,
    localparam int WAY_BITS = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic                       hit,
    output logic [WAY_BITS-1:0]        hit_way,
    output logic                       has_free,
    output logic [WAY_BITS-1:0]        free_way
);

    logic [WAYS-1:0] match_vec;

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_cmp
            assign match_vec[w] = way_valid[w] && (way_tag[w] == probe_tag);
        end
    endgenerate

    always_comb begin
        hit      = |match_vec;
        has_free = ~&way_valid;
        hit_way  = '0;
        free_way = '0;
        // Walk downwards so the lowest index wins.
        for (int k = WAYS - 1; k >= 0; k--) begin
            if (match_vec[k]) begin
                hit_way = WAY_BITS'(k);
            end
            if (!way_valid[k]) begin
                free_way = WAY_BITS'(k);
            end
        end
    end

endmodule

// File: rtl/pcc_sat_inc.sv
// Increment that holds at all-ones.
module pcc_sat_inc #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    always_comb begin
        if (&cur) begin
            nxt = cur;
        end else begin
            nxt = cur + W'(1);
        end
    end

endmodule

// File: rtl/pcc_store.sv
// Cell storage: per-way valid flops (bulk wipe), tag and count arrays.
module pcc_store #(
    parameter  int WAYS     = 16,
    parameter  int SETS     = 32,
    parameter  int TAG_W    = 7,
    parameter  int CNT_W    = 16,
    localparam int SET_BITS = $clog2(SETS),
    localparam int WAY_BITS = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wipe,
    input  logic                       wr_en,
    input  logic [SET_BITS-1:0]        wr_set,
    input  logic [WAY_BITS-1:0]        wr_way,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic [CNT_W-1:0]           wr_cnt,
    input  logic [SET_BITS-1:0]        lk_set,
    output logic [WAYS-1:0]            lk_valid,
    output logic [WAYS-1:0][TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0][CNT_W-1:0] lk_cnt,
    input  logic [SET_BITS-1:0]        sc_set,
    input  logic [WAY_BITS-1:0]        sc_way,
    output logic                       sc_valid,
    output logic [TAG_W-1:0]           sc_tag,
    output logic [CNT_W-1:0]           sc_cnt
);

    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0][CNT_W-1:0] cnt_q   [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
            end
        end else if (wipe) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            cnt_q[wr_set][wr_way] <= wr_cnt;
        end
    end

    assign lk_valid = valid_q[lk_set];
    assign lk_tag   = tag_q[lk_set];
    assign lk_cnt   = cnt_q[lk_set];

    assign sc_valid = valid_q[sc_set][sc_way];
    assign sc_tag   = tag_q[sc_set][sc_way];
    assign sc_cnt   = cnt_q[sc_set][sc_way];

endmodule

// File: rtl/cooc_pair_cache.sv
module cooc_pair_cache
    import pcc_pkg::*;
#(
    parameter  int LVL_W    = 6,
    parameter  int WAYS     = 16,
    parameter  int SET_BITS = 5,
    parameter  int CNT_W    = 16,
    localparam int KEY_W    = 2 * LVL_W,
    localparam int TAG_W    = KEY_W - SET_BITS,
    localparam int SETS     = 1 << SET_BITS,
    localparam int CAP      = SETS * WAYS,
    localparam int WAY_BITS = $clog2(WAYS),
    localparam int IDX_W    = $clog2(CAP),
    localparam int OCC_W    = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_clear,
    input  logic             pair_valid,
    input  logic [LVL_W-1:0] pair_row,
    input  logic [LVL_W-1:0] pair_col,
    input  logic             dump_go,
    output logic             ovf_flag,
    output logic             rd_valid,
    output logic [LVL_W-1:0] rd_row,
    output logic [LVL_W-1:0] rd_col,
    output logic [CNT_W-1:0] rd_count,
    output logic             rd_last
);

    pcc_state_e state_q, state_d;

    // ---------------- accumulate path ----------------
    logic [KEY_W-1:0]           pair_key;
    logic [SET_BITS-1:0]        pair_set;
    logic [TAG_W-1:0]           pair_tag;
    logic [WAYS-1:0]            lk_valid;
    logic [WAYS-1:0][TAG_W-1:0] lk_tag;
    logic [WAYS-1:0][CNT_W-1:0] lk_cnt;
    logic                       hit, has_free;
    logic [WAY_BITS-1:0]        hit_way, free_way, upd_way;
    logic [CNT_W-1:0]           inc_cnt, upd_cnt;
    logic                       accept, upd_en, alloc, miss_full;
    logic [OCC_W-1:0]           occ_q;

    // ---------------- readout path ----------------
    logic [IDX_W-1:0]    scan_idx_q;
    logic [OCC_W-1:0]    sent_q;
    logic [SET_BITS-1:0] scan_set;
    logic [WAY_BITS-1:0] scan_way;
    logic                scan_v;
    logic [TAG_W-1:0]    scan_tag;
    logic [CNT_W-1:0]    scan_cnt;
    logic [KEY_W-1:0]    scan_key;
    logic                scan_final;
    logic                emit;

    assign pair_key = {pair_row, pair_col};
    assign pair_set = pair_key[SET_BITS-1:0];
    assign pair_tag = pair_key[KEY_W-1:SET_BITS];

    assign scan_set = scan_idx_q[IDX_W-1:WAY_BITS];
    assign scan_way = scan_idx_q[WAY_BITS-1:0];
    assign scan_key = {scan_tag, scan_set};

    pcc_way_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_match (
        .way_valid (lk_valid),
        .way_tag   (lk_tag),
        .probe_tag (pair_tag),
        .hit       (hit),
        .hit_way   (hit_way),
        .has_free  (has_free),
        .free_way  (free_way)
    );

    pcc_sat_inc #(
        .W (CNT_W)
    ) u_inc (
        .cur (lk_cnt[hit_way]),
        .nxt (inc_cnt)
    );

    always_comb begin
        accept    = (state_q == ST_ACCUM) && pair_valid && !win_clear;
        upd_en    = accept && (hit || has_free);
        alloc     = accept && !hit && has_free;
        miss_full = accept && !hit && !has_free;
        upd_way   = hit ? hit_way : free_way;
        upd_cnt   = hit ? inc_cnt : CNT_W'(1);
    end

    pcc_store #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .TAG_W (TAG_W),
        .CNT_W (CNT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (win_clear),
        .wr_en    (upd_en),
        .wr_set   (pair_set),
        .wr_way   (upd_way),
        .wr_tag   (pair_tag),
        .wr_cnt   (upd_cnt),
        .lk_set   (pair_set),
        .lk_valid (lk_valid),
        .lk_tag   (lk_tag),
        .lk_cnt   (lk_cnt),
        .sc_set   (scan_set),
        .sc_way   (scan_way),
        .sc_valid (scan_v),
        .sc_tag   (scan_tag),
        .sc_cnt   (scan_cnt)
    );

    // Occupancy and sticky overflow for the current window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q    <= '0;
            ovf_flag <= 1'b0;
        end else if (win_clear) begin
            occ_q    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (alloc) begin
                occ_q <= occ_q + OCC_W'(1);
            end
            if (miss_full) begin
                ovf_flag <= 1'b1;
            end
        end
    end

    assign emit       = (state_q == ST_SCAN) && scan_v && !win_clear;
    assign scan_final = ((sent_q + OCC_W'(1)) == occ_q);

    // ---------------- state machine ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCUM: begin
                if (dump_go && (occ_q != '0)) begin
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (scan_v && scan_final) begin
                    state_d = ST_ACCUM;
                end
            end
            default: state_d = ST_ACCUM;
        endcase
        if (win_clear) begin
            state_d = ST_ACCUM;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACCUM;
        end else begin
            state_q <= state_d;
        end
    end

    // Scan walker: one cell per cycle, set-major order.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_idx_q <= '0;
            sent_q     <= '0;
        end else if (win_clear || (state_q == ST_ACCUM)) begin
            scan_idx_q <= '0;
            sent_q     <= '0;
        end else begin
            scan_idx_q <= scan_idx_q + IDX_W'(1);
            if (scan_v) begin
                sent_q <= sent_q + OCC_W'(1);
            end
        end
    end

    // Registered readout outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_row   <= '0;
            rd_col   <= '0;
            rd_count <= '0;
        end else begin
            rd_valid <= emit;
            rd_last  <= emit && scan_final;
            if (emit) begin
                rd_row   <= scan_key[KEY_W-1:LVL_W];
                rd_col   <= scan_key[LVL_W-1:0];
                rd_count <= scan_cnt;
            end
        end
    end

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker
    import pcc_pkg::*;
#(
    parameter int OCC_W = 10,
    parameter int CAP   = 512,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_clear,
    input logic             dump_go,
    input pcc_state_e       state,
    input logic [OCC_W-1:0] occ,
    input logic             ovf_flag,
    input logic             rd_valid,
    input logic             rd_last,
    input logic [CNT_W-1:0] rd_count
);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !win_clear) |=> ovf_flag) else $error("ovf dropped"); // R5

    AST_CLEAR_DROPS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        win_clear |=> !ovf_flag) else $error("ovf after clear"); // R6

    AST_CLEAR_HALTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        win_clear |=> (!rd_valid && state == ST_ACCUM)) else $error("read after clear"); // R6

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid) else $error("last without valid"); // R8

    AST_LAST_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> (state == ST_ACCUM)) else $error("scan continues"); // R8

    AST_QUIET_IN_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM && $past(state) == ST_ACCUM) |-> !rd_valid) else $error("stray entry"); // R7

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(CAP)) else $error("occupancy over capacity"); // R1

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_count != '0)) else $error("zero count read"); // R4

    AST_EMPTY_NO_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM && dump_go && occ == '0) |=> (state == ST_ACCUM)) else $error("empty scan"); // R10

endmodule

bind cooc_pair_cache pcc_checker #(
    .OCC_W (OCC_W),
    .CAP   (CAP),
    .CNT_W (CNT_W)
) u_pcc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_clear (win_clear),
    .dump_go   (dump_go),
    .state     (state_q),
    .occ       (occ_q),
    .ovf_flag  (ovf_flag),
    .rd_valid  (rd_valid),
    .rd_last   (rd_last),
    .rd_count  (rd_count)
);

// File: tb/cooc_pair_cache_bench.sv
`timescale 1ns/1ps
module cooc_pair_cache_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_clear = 1'b0;
    logic        pair_valid = 1'b0;
    logic [5:0]  pair_row = '0;
    logic [5:0]  pair_col = '0;
    logic        dump_go = 1'b0;
    logic        ovf_flag, rd_valid, rd_last;
    logic [5:0]  rd_row, rd_col;
    logic [15:0] rd_count;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cooc_pair_cache u_cooc_pair_cache (
        .clk (clk), .rst_n (rst_n), .win_clear (win_clear),
        .pair_valid (pair_valid), .pair_row (pair_row), .pair_col (pair_col),
        .dump_go (dump_go), .ovf_flag (ovf_flag), .rd_valid (rd_valid),
        .rd_row (rd_row), .rd_col (rd_col), .rd_count (rd_count), .rd_last (rd_last)
    );

    // Stimulus table: keys base + stride*d (12-bit wrap), d < n, whole list repeated rep times.
    typedef struct packed {
        logic [11:0] base;
        logic [11:0] stride;
        logic [9:0]  n;
        logic [7:0]  rep;
        logic [9:0]  n_exp;
        logic        ovf_exp;
    } pat_t;

    localparam int NPAT = 7;
    localparam pat_t PATS [NPAT] = '{
        '{12'h000, 12'h001, 10'd20,  8'd3,  10'd20,  1'b0},  // spread sets
        '{12'hFE5, 12'hFE0, 10'd16,  8'd2,  10'd16,  1'b0},  // one set full, descending tags
        '{12'h013, 12'h020, 10'd17,  8'd1,  10'd16,  1'b1},  // one set overflows
        '{12'hFC0, 12'h000, 10'd1,   8'd40, 10'd1,   1'b0},  // one key back-to-back
        '{12'h100, 12'h021, 10'd40,  8'd2,  10'd40,  1'b0},  // wraps over all sets
        '{12'h000, 12'h001, 10'd512, 8'd1,  10'd512, 1'b0},  // exactly full
        '{12'h000, 12'h001, 10'd513, 8'd1,  10'd512, 1'b1}   // one past full
    };

    // Requirement-level model of the window contents.
    int m_cnt [4096];
    int m_key [512];
    int m_fill [32];
    int m_n;
    bit m_ovf;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4096; i++) m_cnt[i] = 0;
        for (int i = 0; i < 32; i++) m_fill[i] = 0;
        m_n = 0;
        m_ovf = 1'b0;
    endtask

    task automatic model_push(input int key);
        if (m_cnt[key] != 0) begin
            if (m_cnt[key] < 65535) m_cnt[key]++;
        end else if (m_fill[key % 32] < 16) begin
            m_cnt[key] = 1;
            m_key[m_n] = key;
            m_n++;
            m_fill[key % 32]++;
        end else begin
            m_ovf = 1'b1;
        end
    endtask

    task automatic push(input logic [11:0] key);
        pair_valid = 1'b1;
        pair_row = key[11:6];
        pair_col = key[5:0];
        @(negedge clk);
        pair_valid = 1'b0;
        model_push(int'(key));
    endtask

    task automatic clear_window();
        win_clear = 1'b1;
        @(negedge clk);
        win_clear = 1'b0;
        model_clear();
    endtask

    // Readout and compare. Expected order: set 0..31, within a set by first sighting (R7).
    task automatic dump_check(input string req, input bit disturb);
        int ek [512];
        int ec [512];
        int ne = 0;
        int got = 0;
        int lim;
        bit seen_last = 1'b0;
        for (int s = 0; s < 32; s++)
            for (int i = 0; i < m_n; i++)
                if (m_key[i] % 32 == s) begin
                    ek[ne] = m_key[i];
                    ec[ne] = m_cnt[m_key[i]];
                    ne++;
                end
        lim = (ne == 0) ? 20 : 700;
        dump_go = 1'b1;
        @(negedge clk);
        dump_go = 1'b0;
        if (disturb) begin
            dump_go = 1'b1;
            pair_valid = 1'b1;
            pair_row = 6'h2A;
            pair_col = 6'h15;
        end
        for (int c = 0; c < lim && !seen_last; c++) begin
            @(negedge clk);
            if (rd_valid) begin
                if (got < ne) begin
                    check({rd_row, rd_col} == 12'(ek[got]), req, "entry key",
                          int'({rd_row, rd_col}), ek[got]);
                    check(int'(rd_count) == ec[got], req, "entry count",
                          int'(rd_count), ec[got]);
                    check(rd_last == (got == ne - 1), "R8", "last marker",
                          int'(rd_last), int'(got == ne - 1));
                end
                got++;
                if (rd_last) begin
                    seen_last = 1'b1;
                    dump_go = 1'b0;
                    pair_valid = 1'b0;
                end
            end
        end
        dump_go = 1'b0;
        pair_valid = 1'b0;
        check(got == ne, req, "entries streamed", got, ne);
    endtask

    initial begin : watchdog
        repeat (250000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check(ovf_flag == 1'b0, "R11", "ovf after reset", int'(ovf_flag), 0);
        check(rd_valid == 1'b0, "R11", "rd_valid after reset", int'(rd_valid), 0);
        check(rd_last == 1'b0, "R11", "rd_last after reset", int'(rd_last), 0);
        // R10: empty store readout
        dump_check("R10", 1'b0);

        // Table walk: R1 R2 R4 R5 R7
        for (int p = 0; p < NPAT; p++) begin
            clear_window();
            for (int r = 0; r < int'(PATS[p].rep); r++)
                for (int d = 0; d < int'(PATS[p].n); d++)
                    push(12'(int'(PATS[p].base) + int'(PATS[p].stride) * d));
            check(ovf_flag == PATS[p].ovf_exp, "R5", "table ovf", int'(ovf_flag),
                  int'(PATS[p].ovf_exp));
            check(m_n == int'(PATS[p].n_exp), "R1", "table model size", m_n,
                  int'(PATS[p].n_exp));
            dump_check((p == 1) ? "R4" : "R2", 1'b0);
        end

        // R3: saturation
        clear_window();
        for (int i = 0; i < 65537; i++) push(12'h7E5);
        dump_check("R3", 1'b0);

        // R9: pairs and dump requests during SCAN ignored
        clear_window();
        for (int d = 0; d < 24; d++) push(12'(d * 7));
        dump_check("R9", 1'b1);
        dump_check("R9", 1'b0);

        // R5: overflow sticky while hits keep counting
        clear_window();
        for (int d = 0; d < 17; d++) push(12'(12'h009 + d * 32));
        check(ovf_flag == 1'b1, "R5", "ovf set", int'(ovf_flag), 1);
        for (int d = 0; d < 5; d++) push(12'(12'h009 + d * 32));
        check(ovf_flag == 1'b1, "R5", "ovf sticky", int'(ovf_flag), 1);
        dump_check("R5", 1'b0);

        // R6: clear mid-readout, with a pair in the same cycle
        dump_go = 1'b1;
        @(negedge clk);
        dump_go = 1'b0;
        repeat (4) @(negedge clk);
        win_clear = 1'b1;
        pair_valid = 1'b1;
        pair_row = 6'h11;
        pair_col = 6'h22;
        @(negedge clk);
        win_clear = 1'b0;
        pair_valid = 1'b0;
        model_clear();
        check(ovf_flag == 1'b0, "R6", "ovf after clear", int'(ovf_flag), 0);
        for (int c = 0; c < 10; c++) begin
            check(rd_valid == 1'b0, "R6", "no entry after clear", int'(rd_valid), 0);
            @(negedge clk);
        end
        dump_check("R6", 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule